// File: doc/BRIEF.md
# Pseudo-SRAM Deep Power-Down Sequencer

This block sits on the host side of an asynchronous pseudo-static RAM and owns the pin that moves the memory between normal operation and deep power-down. After reset it keeps the power-state pin high through a power-on settling interval. It then opens the memory to the access controller. On request it parks the chip-enable high and pulls the power-state pin low for no less than the minimum power-down pulse. When asked to leave, it raises the pin again and keeps access closed until the wake-up recovery interval has passed.

The access controller sees a single `ready` level that tells it when it may drive the memory. It also sees a sticky `data_lost` flag that reports that the array contents have been destroyed. The controller's own chip-enable passes through this block, which overrides it to the inactive level whenever access is closed. Every interval is given in physical time and converted to system clocks from a clock-period parameter, always rounding up.

Top module: `psram_dpd_seq`

## Requirements
- R1: After `rst_n` rises, `ready` stays low, `mem_ce2` stays high and `data_lost` stays low until the (N_CHP+2)-th rising clock edge. That count is two edges of reset synchronisation plus N_CHP settling clocks. `ready` goes high after that edge. Asserting `rst_n` low returns the block to this state at any time and clears `data_lost`.
- R2: While `ready` is high, `mem_ce1_n` equals `acc_ce1_n`. While `ready` is low, `mem_ce1_n` is 1.
- R3: A `dpd_req` level sampled high at a clock edge while `ready` is high drops `ready` after that edge. One full clock follows with `mem_ce2` still high and `mem_ce1_n` forced to 1. `mem_ce2` then falls on the next edge, and `mem_ce1_n` stays 1 for as long as `mem_ce2` is low.
- R4: Each low period of `mem_ce2` lasts at least N_DPD clocks. Without an exit request it lasts indefinitely.
- R5: A `wake_req` sampled high during the low period, before N_DPD clocks have passed, is remembered. `mem_ce2` then rises after exactly N_DPD low clocks.
- R6: A `wake_req` sampled high at an edge after the minimum low time has already passed raises `mem_ce2` on that same edge.
- R7: After `mem_ce2` rises from power-down, `ready` stays low for exactly N_CH clocks and then rises.
- R8: `data_lost` goes to 1 on the edge where `mem_ce2` rises from power-down. It holds until `lost_clr` is sampled high at an edge on which no new exit occurs. On an edge that carries both, the exit wins.
- R9: `dpd_req` has no effect unless `ready` is high, so it is ignored during settling, power-down and recovery. `wake_req` has no effect outside the power-down low period and is not remembered for a later one.
- R10: N_CHP = ceil(T_CHP_US*1000/CLK_NS). N_CH = ceil(T_CH_US*1000/CLK_NS). N_DPD = ceil(T_DPD_MS*1000000/CLK_NS). Each value is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dpd_req | input | 1 | Request to enter deep power-down, sampled each edge |
| wake_req | input | 1 | Request to leave deep power-down, sampled each edge |
| lost_clr | input | 1 | Clears the data-lost flag, sampled each edge |
| acc_ce1_n | input | 1 | Active-low chip enable from the access controller |
| mem_ce1_n | output | 1 | Active-low chip enable to the memory |
| mem_ce2 | output | 1 | Power-state pin to the memory; low means deep power-down |
| ready | output | 1 | High when the memory may be accessed |
| data_lost | output | 1 | Sticky flag: memory contents were lost in a power-down |

## Verification
The bench runs with a clock-period parameter that does not divide the intervals evenly. A design that truncates instead of rounding up would shorten settling, the power-down pulse and recovery by one clock each. Exit requests are issued early, late, before entry and during recovery. A design that drops an early exit would stay in power-down forever. One that remembers a stale exit would cut the next pulse to its minimum. One that does not wait out the minimum would end the pulse short. Entry is checked for the one-clock window in which the chip enable is already parked while the power-state pin is still high. Without that window the chip enable would be active at the moment the pin falls.

// File: rtl/psram_dpd_pkg.sv
`timescale 1ns/1ps
package psram_dpd_pkg;

  typedef enum logic [2:0] {
    PH_SETTLE = 3'd0,
    PH_RUN    = 3'd1,
    PH_PARK   = 3'd2,
    PH_LOW    = 3'd3,
    PH_HOLD   = 3'd4
  } dpd_phase_e;

  // Number of whole clocks covering dur_ns, rounded up, never below one.
  function automatic int unsigned clocks_ceil(input longint unsigned dur_ns,
                                              input longint unsigned clk_ns);
    longint unsigned q;
    q = (dur_ns + clk_ns - 64'd1) / clk_ns;
    if (q == 64'd0) q = 64'd1;
    return q[31:0];
  endfunction

endpackage

// File: rtl/psram_dpd_rstsync.sv
`timescale 1ns/1ps
module psram_dpd_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/psram_dpd_timer.sv
`timescale 1ns/1ps
module psram_dpd_timer #(
  parameter int unsigned     W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/psram_dpd_flags.sv
`timescale 1ns/1ps
module psram_dpd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wake,
  input  logic drop_wake,
  input  logic set_lost,
  input  logic clr_lost,
  output logic wake_pend,
  output logic data_lost
);
  logic pend_q, pend_d;
  logic lost_q, lost_d;

  always_comb begin
    pend_d = pend_q;
    if (drop_wake)     pend_d = 1'b0;
    else if (arm_wake) pend_d = 1'b1;

    lost_d = lost_q;
    if (set_lost)      lost_d = 1'b1;
    else if (clr_lost) lost_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lost_q <= lost_d;
    end
  end

  assign wake_pend = pend_q;
  assign data_lost = lost_q;
endmodule

// File: rtl/psram_dpd_seq.sv
`timescale 1ns/1ps
module psram_dpd_seq
  import psram_dpd_pkg::*;
#(
  parameter int unsigned CLK_NS    = 8,
  parameter int unsigned T_DPD_MS  = 10,
  parameter int unsigned T_CH_US   = 300,
  parameter int unsigned T_CHP_US  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dpd_req,
  input  logic wake_req,
  input  logic lost_clr,
  input  logic acc_ce1_n,
  output logic mem_ce1_n,
  output logic mem_ce2,
  output logic ready,
  output logic data_lost
);
  localparam int unsigned N_DPD = clocks_ceil(64'(T_DPD_MS) * 64'd1000000, 64'(CLK_NS));
  localparam int unsigned N_CH  = clocks_ceil(64'(T_CH_US) * 64'd1000, 64'(CLK_NS));
  localparam int unsigned N_CHP = clocks_ceil(64'(T_CHP_US) * 64'd1000, 64'(CLK_NS));
  localparam int unsigned N_MX1 = (N_DPD > N_CH) ? N_DPD : N_CH;
  localparam int unsigned N_MAX = (N_MX1 > N_CHP) ? N_MX1 : N_CHP;
  localparam int unsigned CW    = $clog2(N_MAX + 1);
  localparam logic [CW-1:0] LD_DPD = CW'(N_DPD - 1);
  localparam logic [CW-1:0] LD_CH  = CW'(N_CH - 1);
  localparam logic [CW-1:0] LD_CHP = CW'(N_CHP - 1);

  logic          srst_n;
  dpd_phase_e    ph_q, ph_d;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          wake_pend;
  logic          leave_pd;
  logic          arm_wake;

  psram_dpd_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Next-state logic
  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = LD_DPD;
    leave_pd = 1'b0;
    case (ph_q)
      PH_SETTLE: if (tmr_zero) ph_d = PH_RUN;
      PH_RUN:    if (dpd_req)  ph_d = PH_PARK;
      PH_PARK: begin
        ph_d     = PH_LOW;
        tmr_load = 1'b1;
        tmr_val  = LD_DPD;
      end
      PH_LOW: begin
        if (tmr_zero && (wake_pend || wake_req)) begin
          leave_pd = 1'b1;
          ph_d     = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = LD_CH;
        end
      end
      PH_HOLD:   if (tmr_zero) ph_d = PH_RUN;
      default:   ph_d = PH_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ph_q <= PH_SETTLE;
    else         ph_q <= ph_d;
  end

  psram_dpd_timer #(.W(CW), .RST_VAL(LD_CHP)) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign arm_wake = (ph_q == PH_LOW) && wake_req && !leave_pd;

  psram_dpd_flags u_flags (
    .clk       (clk),
    .rst_n     (srst_n),
    .arm_wake  (arm_wake),
    .drop_wake (leave_pd),
    .set_lost  (leave_pd),
    .clr_lost  (lost_clr),
    .wake_pend (wake_pend),
    .data_lost (data_lost)
  );

  assign ready     = (ph_q == PH_RUN);
  assign mem_ce2   = (ph_q != PH_LOW);
  assign mem_ce1_n = acc_ce1_n || (ph_q != PH_RUN);
endmodule

// File: rtl/psram_dpd_seq_chk.sv
`timescale 1ns/1ps
module psram_dpd_seq_chk
  import psram_dpd_pkg::*;
#(
  parameter int unsigned CLK_NS   = 8,
  parameter int unsigned T_DPD_MS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic acc_ce1_n,
  input logic lost_clr,
  input logic mem_ce1_n,
  input logic mem_ce2,
  input logic ready,
  input logic data_lost
);
  localparam int unsigned N_DPD = clocks_ceil(64'(T_DPD_MS) * 64'd1000000, 64'(CLK_NS));

  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (mem_ce2)  low_run <= '0;
    else               low_run <= low_run + 32'd1;
  end

  assert_ce1_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce1_n == acc_ce1_n));

  assert_ce1_parked_in_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce2 |-> mem_ce1_n);

  assert_ce1_before_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce2) |-> ($past(mem_ce1_n) && !ready));

  assert_min_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce2) |-> (low_run >= N_DPD));

  assert_closed_on_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce2) |-> !ready);

  assert_lost_on_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce2) |-> data_lost);

  assert_lost_clear_by_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_lost) |-> $past(lost_clr));
endmodule

bind psram_dpd_seq psram_dpd_seq_chk #(.CLK_NS(CLK_NS), .T_DPD_MS(T_DPD_MS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_ce1_n (acc_ce1_n),
  .lost_clr  (lost_clr),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .ready     (ready),
  .data_lost (data_lost)
);

// File: tb/psram_dpd_seq_test.sv
`timescale 1ns/1ps
module psram_dpd_seq_test;
  // Uneven clock parameter so every interval needs rounding up (R10).
  localparam int unsigned P_CLK  = 7000;
  localparam int unsigned P_DPD  = 1;
  localparam int unsigned P_CH   = 50;
  localparam int unsigned P_CHP  = 30;
  localparam int NCHP = 5;    // ceil(30000/7000)
  localparam int NCH  = 8;    // ceil(50000/7000)
  localparam int NDPD = 143;  // ceil(1000000/7000)

  localparam int M_SETTLE = 0, M_RUN = 1, M_PARK = 2, M_LOW = 3, M_HOLD = 4;

  logic clk = 1'b0;
  logic rst_n, dpd_req, wake_req, lost_clr, acc_ce1_n;
  logic mem_ce1_n, mem_ce2, ready, data_lost;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  psram_dpd_seq #(.CLK_NS(P_CLK), .T_DPD_MS(P_DPD), .T_CH_US(P_CH), .T_CHP_US(P_CHP)) uut (
    .clk(clk), .rst_n(rst_n), .dpd_req(dpd_req), .wake_req(wake_req),
    .lost_clr(lost_clr), .acc_ce1_n(acc_ce1_n), .mem_ce1_n(mem_ce1_n),
    .mem_ce2(mem_ce2), .ready(ready), .data_lost(data_lost)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase plus elapsed edges.
  int  m_ph = M_SETTLE;
  int  m_el = 0;
  bit  m_pend = 0;
  bit  m_lost = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = M_SETTLE; m_el = 0; m_pend = 0; m_lost = 0;
    end else begin
      bit exit_now;
      exit_now = 0;
      m_el++;
      case (m_ph)
        M_SETTLE: if (m_el == NCHP + 2) begin m_ph = M_RUN; m_el = 0; end
        M_RUN:    if (dpd_req) begin m_ph = M_PARK; m_el = 0; end
        M_PARK:   begin m_ph = M_LOW; m_el = 0; end
        M_LOW: begin
          if (m_el >= NDPD && (m_pend || wake_req)) begin
            exit_now = 1; m_ph = M_HOLD; m_el = 0; m_pend = 0;
          end else if (wake_req) m_pend = 1;
        end
        M_HOLD:   if (m_el == NCH) begin m_ph = M_RUN; m_el = 0; end
        default:  m_ph = M_SETTLE;
      endcase
      if (exit_now) m_lost = 1;
      else if (lost_clr) m_lost = 0;
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      chk(m_ph == M_SETTLE ? "R1 ready" : "R7 ready", int'(ready), int'(m_ph == M_RUN));
      chk("R4 mem_ce2", int'(mem_ce2), int'(m_ph != M_LOW));
      chk("R2 mem_ce1_n", int'(mem_ce1_n), int'((m_ph == M_RUN) ? acc_ce1_n : 1'b1));
      chk("R8 data_lost", int'(data_lost), int'(m_lost));
    end
  end

  // Length of the most recent power-down low period, in clocks.
  int low_run = 0;
  int last_low = 0;
  always @(negedge clk) begin
    if (!mem_ce2) low_run++;
    else begin
      if (low_run != 0) last_low = low_run;
      low_run = 0;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (ready || n > 1000) break;
      n++;
    end
  endtask

  // Waits for mem_ce2 to rise, then counts closed clocks before ready.
  task automatic wait_hold(output int h);
    int guard;
    guard = 0;
    while (!mem_ce2 && guard < 1000) begin @(negedge clk); guard++; end
    h = 0;
    while (!ready && h < 1000) begin h++; @(negedge clk); end
  endtask

  task automatic pulse_dpd();  tick(); dpd_req = 1;  tick(); dpd_req = 0;  endtask
  task automatic pulse_wake(); tick(); wake_req = 1; tick(); wake_req = 0; endtask
  task automatic pulse_clr();  tick(); lost_clr = 1; tick(); lost_clr = 0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int h;
    rst_n = 0; dpd_req = 0; wake_req = 0; lost_clr = 0; acc_ce1_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset ready", int'(ready), 0);
    chk("R1 reset mem_ce2", int'(mem_ce2), 1);
    chk("R1 reset data_lost", int'(data_lost), 0);

    // R1, R10: settling length with rounding up
    @(posedge clk); #1; rst_n = 1;
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ready || n > 100) break;
    end
    chk("R1 R10 settle edges", n, NCHP + 2);

    // R2: pass-through of the controller's chip enable
    tick(); acc_ce1_n = 0; @(negedge clk); chk("R2 pass low", int'(mem_ce1_n), 0);
    tick(); acc_ce1_n = 1; @(negedge clk); chk("R2 pass high", int'(mem_ce1_n), 1);

    // R3: entry sequence with the controller holding its enable active
    tick(); acc_ce1_n = 0; dpd_req = 1;
    @(negedge clk); chk("R3 before sample ready", int'(ready), 1);
    tick(); dpd_req = 0;
    @(negedge clk);
    chk("R3 park ready", int'(ready), 0);
    chk("R3 park mem_ce2", int'(mem_ce2), 1);
    chk("R3 park mem_ce1_n", int'(mem_ce1_n), 1);
    tick(); @(negedge clk);
    chk("R3 low mem_ce2", int'(mem_ce2), 0);
    chk("R3 low mem_ce1_n", int'(mem_ce1_n), 1);

    // R5: early exit request is latched
    repeat (10) tick();
    pulse_wake();
    wait_hold(h);
    chk("R5 R10 low length", last_low, NDPD);
    chk("R7 hold length", h, NCH);
    chk("R8 lost set", int'(data_lost), 1);
    repeat (5) tick();
    @(negedge clk); chk("R8 lost sticky", int'(data_lost), 1);
    pulse_clr();
    @(negedge clk); chk("R8 lost cleared", int'(data_lost), 0);

    // R4, R6: no exit request keeps the pin low; a late request acts at once
    pulse_dpd();
    repeat (NDPD + 20) tick();
    @(negedge clk); chk("R4 still low", int'(mem_ce2), 0);
    tick(); wake_req = 1;
    @(negedge clk); chk("R6 before sample", int'(mem_ce2), 0);
    tick(); wake_req = 0;
    @(negedge clk); chk("R6 rose", int'(mem_ce2), 1);
    wait_ready(n);
    chk("R7 late exit hold", n, NCH - 1);

    // R9: stale exit request and entry requests outside ready are ignored
    pulse_wake();
    pulse_dpd();
    repeat (NDPD + 10) tick();
    @(negedge clk); chk("R9 stale wake ignored", int'(mem_ce2), 0);
    pulse_dpd();
    pulse_wake();
    n = 0;
    while (!mem_ce2 && n < 10) begin @(negedge clk); n++; end
    pulse_dpd();
    wait_ready(n);
    repeat (5) tick();
    @(negedge clk);
    chk("R9 dpd in hold ignored ce2", int'(mem_ce2), 1);
    chk("R9 dpd in hold ignored ready", int'(ready), 1);

    // R1, R9: reset in the middle, entry request during settling
    tick(); rst_n = 0;
    repeat (2) tick();
    @(negedge clk); chk("R1 reset clears lost", int'(data_lost), 0);
    tick(); rst_n = 1;
    tick(); dpd_req = 1; repeat (3) tick(); dpd_req = 0;
    wait_ready(n);
    repeat (5) tick();
    @(negedge clk);
    chk("R9 dpd in settle ignored", int'(mem_ce2), 1);
    chk("R1 ready after reapplied reset", int'(ready), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule